// File: doc/BRIEF.md
# ECC Error Report Aggregator

This block sits behind a BCH decoder during a page read. It takes one result per packet: a corrected-bit count, a decode-success flag and an all-erased flag. From these it builds a 32-bit error-report word and two status flags, and it exposes all three through a small select-and-read register port. The first packet of a page has its own count and success bit in the report. The packets after it are merged into one count and one success bit. That merged count is the largest count among those packets, not their sum.

A page read begins with a one-cycle start pulse. The pulse clears the accumulated state and latches how many packets the page holds. When that many results have been taken, the block raises a command-ready flag and freezes the report. It also raises a page-empty flag if every packet of the page reported all-erased. The block does not check erased pages for bitflips; software does that using the empty flag. The decoder, the erased-page bitflip check and data movement are outside this block.

Top module: `ecc_report_agg`

## Requirements
- R1: Under reset, and after reset until the first page start, the command-ready flag and the page-empty flag are 0 and the report word reads 0x00008000. Results that arrive before the first page start are ignored.
- R2: The select input picks what the read-data output shows. Value 0 shows the controller status, with command ready at bit 31. Value 1 shows the transfer status, with page empty at bit 16. Value 2 shows the report word. Value 3 shows zero. Every bit not named in these requirements reads 0. Read data depends combinationally on the select input and the stored state.
- R3: A page-start pulse clears both flags and sets the report to 0x00008000 in the next cycle. It also latches the packet count. If a result is valid in the same cycle as the pulse, the pulse takes priority and the result is dropped.
- R4: The first result taken after a page start writes its corrected count to report bits 5:0. Its decode-success flag goes to report bit 7, where 1 means success.
- R5: Report bits 13:8 hold the largest corrected count among the results taken after the first one in the page.
- R6: Report bit 15 is the AND of the decode-success flags of the results after the first one. It stays 1 when the page has a single packet.
- R7: A corrected count above 63 is recorded as 63, in both count fields.
- R8: Command ready becomes 1 in the same register update that takes the last result of the page. The number of results in the page is the latched packet count, and a count of 0 means 2^PKT_W packets (16 by default).
- R9: At completion, page empty is set only if every result of the page had its all-erased flag set. Counts and success flags are still recorded as usual for an erased page.
- R10: After completion, further results change nothing until the next page start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageStart | input | 1 | One-cycle pulse that starts a page read |
| pktCount | input | PKT_W | Packets in the page, latched at page start (0 means 2^PKT_W) |
| resValid | input | 1 | A packet result is presented this cycle |
| resErrCnt | input | ERR_IN_W | Corrected-bit count of the packet |
| resDecodeOk | input | 1 | 1 when the packet decoded successfully |
| resErased | input | 1 | 1 when the packet was all-erased |
| regSel | input | 2 | Register select for the read port |
| regRdata | output | 32 | Read data for the selected register |

## Verification
Two pairs of events can land in the same cycle. The first pair is a page-start pulse and a valid result. The bench provokes this both at the start of a page and partway through one, and the reference model requires that the result is dropped and the state clears. The second pair is the final result of a page and a stray result in the cycle just after completion. The bench drives results back to back across the completion point. It judges that the final result sets command ready and the empty flag in the same update, while the next one leaves every register unchanged. A random phase mixes all four events freely, and every register is compared against the model on every cycle.

// File: rtl/ecc_report_pkg.sv
`timescale 1ns/1ps
package ecc_report_pkg;
  localparam int REP_CNT_W = 6;
  localparam int READY_BIT = 31;
  localparam int EMPTY_BIT = 16;
  localparam int OK0_BIT   = 7;
  localparam int MAXN_LSB  = 8;
  localparam int OKN_BIT   = 15;

  typedef struct packed {
    logic clear;
    logic loadFirst;
    logic loadLater;
    logic finish;
  } aggStrobes_t;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_XFER   = 2'd1,
    SEL_REPORT = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;
endpackage

// File: rtl/ecc_report_ctrl.sv
`timescale 1ns/1ps
module ecc_report_ctrl
  import ecc_report_pkg::*;
#(
  parameter int PKT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pageStart,
  input  logic [PKT_W-1:0] pktCount,
  input  logic             resValid,
  output aggStrobes_t      strobes
);
  logic             active;
  logic [PKT_W-1:0] pktSeen;
  logic [PKT_W-1:0] target;
  logic [PKT_W-1:0] nextSeen;
  logic             accept;

  assign nextSeen = pktSeen + 1'b1;
  assign accept   = resValid && active && !pageStart;

  always_comb begin
    strobes.clear     = pageStart;
    strobes.loadFirst = accept && (pktSeen == '0);
    strobes.loadLater = accept && (pktSeen != '0);
    strobes.finish    = accept && (nextSeen == target);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      pktSeen <= '0;
      target  <= '0;
    end else if (pageStart) begin
      active  <= 1'b1;
      pktSeen <= '0;
      target  <= pktCount;
    end else if (accept) begin
      pktSeen <= nextSeen;
      if (nextSeen == target) active <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_report_dp.sv
`timescale 1ns/1ps
module ecc_report_dp
  import ecc_report_pkg::*;
#(
  parameter int ERR_IN_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  aggStrobes_t         strobes,
  input  logic [ERR_IN_W-1:0] resErrCnt,
  input  logic                resDecodeOk,
  input  logic                resErased,
  output logic [31:0]         ctrlStatus,
  output logic [31:0]         xferStatus,
  output logic [31:0]         reportWord
);
  logic [REP_CNT_W-1:0] satCnt;
  logic [REP_CNT_W-1:0] firstCnt;
  logic [REP_CNT_W-1:0] laterMax;
  logic                 firstOk;
  logic                 laterOk;
  logic                 erasedAcc;
  logic                 pageEmpty;
  logic                 cmdReady;

  generate
    if (ERR_IN_W > REP_CNT_W) begin : g_sat
      localparam logic [ERR_IN_W-1:0] LIMIT_IN = ERR_IN_W'((1 << REP_CNT_W) - 1);
      assign satCnt = (resErrCnt > LIMIT_IN) ? {REP_CNT_W{1'b1}}
                                             : resErrCnt[REP_CNT_W-1:0];
    end else begin : g_ext
      assign satCnt = REP_CNT_W'(resErrCnt);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      firstCnt  <= '0;
      firstOk   <= 1'b0;
      laterMax  <= '0;
      laterOk   <= 1'b1;
      erasedAcc <= 1'b1;
      pageEmpty <= 1'b0;
      cmdReady  <= 1'b0;
    end else begin
      if (strobes.loadFirst) begin
        firstCnt <= satCnt;
        firstOk  <= resDecodeOk;
      end
      if (strobes.loadLater) begin
        if (satCnt > laterMax) laterMax <= satCnt;
        laterOk <= laterOk & resDecodeOk;
      end
      if (strobes.loadFirst || strobes.loadLater)
        erasedAcc <= erasedAcc & resErased;
      if (strobes.finish) begin
        cmdReady  <= 1'b1;
        pageEmpty <= erasedAcc & resErased;
      end
    end
  end

  always_comb begin
    ctrlStatus = '0;
    ctrlStatus[READY_BIT] = cmdReady;
    xferStatus = '0;
    xferStatus[EMPTY_BIT] = pageEmpty;
    reportWord = '0;
    reportWord[REP_CNT_W-1:0] = firstCnt;
    reportWord[OK0_BIT] = firstOk;
    reportWord[MAXN_LSB +: REP_CNT_W] = laterMax;
    reportWord[OKN_BIT] = laterOk;
  end
endmodule

// File: rtl/ecc_report_agg.sv
`timescale 1ns/1ps
module ecc_report_agg
  import ecc_report_pkg::*;
#(
  parameter int PKT_W    = 4,
  parameter int ERR_IN_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pageStart,
  input  logic [PKT_W-1:0]    pktCount,
  input  logic                resValid,
  input  logic [ERR_IN_W-1:0] resErrCnt,
  input  logic                resDecodeOk,
  input  logic                resErased,
  input  logic [1:0]          regSel,
  output logic [31:0]         regRdata
);
  aggStrobes_t strobes;
  logic [31:0] ctrlStatus;
  logic [31:0] xferStatus;
  logic [31:0] reportWord;

  ecc_report_ctrl #(.PKT_W(PKT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .pktCount(pktCount),
    .resValid(resValid), .strobes(strobes)
  );

  ecc_report_dp #(.ERR_IN_W(ERR_IN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .resErrCnt(resErrCnt),
    .resDecodeOk(resDecodeOk), .resErased(resErased),
    .ctrlStatus(ctrlStatus), .xferStatus(xferStatus), .reportWord(reportWord)
  );

  always_comb begin
    case (regSel_e'(regSel))
      SEL_CTRL:   regRdata = ctrlStatus;
      SEL_XFER:   regRdata = xferStatus;
      SEL_REPORT: regRdata = reportWord;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_report_agg_chk.sv
`timescale 1ns/1ps
module ecc_report_agg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        pageStart,
  input logic        resValid,
  input logic [31:0] ctrlStatus,
  input logic [31:0] xferStatus,
  input logic [31:0] reportWord
);
  assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    pageStart |=> (reportWord == 32'h0000_8000) && !ctrlStatus[31] && !xferStatus[16]);

  assert_frozen_after_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStatus[31] && !pageStart) |=> $stable(reportWord) && $stable(xferStatus) && ctrlStatus[31]);

  assert_empty_needs_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    xferStatus[16] |-> ctrlStatus[31]);

  assert_later_ok_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!pageStart && !reportWord[15]) |=> !reportWord[15]);

  assert_later_max_monotone_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pageStart |=> reportWord[13:8] >= $past(reportWord[13:8]));

  assert_ready_from_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlStatus[31]) |-> $past(resValid) && !$past(pageStart));
endmodule

bind ecc_report_agg ecc_report_agg_chk u_chk (
  .clk(clk), .rstN(rstN), .pageStart(pageStart), .resValid(resValid),
  .ctrlStatus(ctrlStatus), .xferStatus(xferStatus), .reportWord(reportWord)
);

// File: tb/ecc_report_agg_tb.sv
`timescale 1ns/1ps
module ecc_report_agg_tb;
  localparam int PKT_W = 4;
  localparam int ERR_IN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pageStart = 1'b0;
  logic [PKT_W-1:0] pktCount = '0;
  logic resValid = 1'b0;
  logic [ERR_IN_W-1:0] resErrCnt = '0;
  logic resDecodeOk = 1'b0;
  logic resErased = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [31:0] regRdata;

  int nCompared = 0;
  int nMismatched = 0;
  int cycles = 0;
  string curReq = "R1";

  // reference model state
  int mActive = 0, mSeen = 0, mTarget = 0;
  int mCnt0 = 0, mOk0 = 0, mMaxN = 0, mOkN = 1, mErAcc = 1, mEmpty = 0, mReady = 0;
  int pendingQ[$];

  always #2.5 clk = ~clk;

  ecc_report_agg #(.PKT_W(PKT_W), .ERR_IN_W(ERR_IN_W)) u_dut (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .pktCount(pktCount),
    .resValid(resValid), .resErrCnt(resErrCnt), .resDecodeOk(resDecodeOk),
    .resErased(resErased), .regSel(regSel), .regRdata(regRdata)
  );

  function automatic void clearModel();
    mCnt0 = 0; mOk0 = 0; mMaxN = 0; mOkN = 1; mErAcc = 1; mEmpty = 0; mReady = 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      clearModel(); mActive = 0; mSeen = 0; mTarget = 0;
    end else if (pageStart) begin
      clearModel(); mActive = 1; mSeen = 0;
      mTarget = (pktCount == 0) ? (1 << PKT_W) : int'(pktCount);
    end else if (resValid && mActive == 1) begin
      int s;
      s = (int'(resErrCnt) > 63) ? 63 : int'(resErrCnt);
      if (mSeen == 0) begin
        mCnt0 = s; mOk0 = resDecodeOk;
      end else begin
        if (s > mMaxN) mMaxN = s;
        mOkN = mOkN & resDecodeOk;
      end
      mErAcc = mErAcc & resErased;
      mSeen++;
      if (mSeen == mTarget) begin
        mReady = 1; mEmpty = mErAcc; mActive = 0;
      end
    end
  end

  function automatic logic [31:0] expVal(int sel);
    logic [31:0] v = '0;
    case (sel)
      0: v[31] = mReady[0];
      1: v[16] = mEmpty[0];
      2: begin
        v[5:0] = mCnt0[5:0]; v[7] = mOk0[0];
        v[13:8] = mMaxN[5:0]; v[15] = mOkN[0];
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // R2: every select value is compared on every cycle
  always @(negedge clk) begin
    for (int sel = 0; sel < 4; sel++) begin
      regSel = sel[1:0];
      #0.2;
      nCompared++;
      if (regRdata !== expVal(sel)) begin
        nMismatched++;
        $display("FAIL %s (R2 sel=%0d) t=%0t actual=%h expected=%h",
                 curReq, sel, $time, regRdata, expVal(sel));
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pageStart = 0; resValid = 0;
    end
  endtask

  task automatic startPage(int cnt, bit withRes);
    @(negedge clk);
    pageStart = 1; pktCount = cnt[PKT_W-1:0];
    resValid = withRes; resErrCnt = 8'd55; resDecodeOk = 0; resErased = 0;
    @(negedge clk);
    pageStart = 0; resValid = 0;
  endtask

  task automatic sendRes(int cnt, bit ok, bit er);
    @(negedge clk);
    pageStart = 0; resValid = 1;
    resErrCnt = cnt[ERR_IN_W-1:0]; resDecodeOk = ok; resErased = er;
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    rstN = 1;
    sendRes(20, 1, 1); sendRes(5, 0, 0);
    idle(2);

    curReq = "R4 R5";
    startPage(4, 0);
    sendRes(3, 1, 0); sendRes(10, 1, 0); sendRes(7, 1, 0); sendRes(12, 1, 0);
    idle(2);

    curReq = "R6";
    startPage(3, 0);
    sendRes(0, 0, 0); sendRes(2, 1, 0); sendRes(1, 0, 0);
    idle(1);
    startPage(1, 0);
    sendRes(9, 1, 0);
    idle(2);

    curReq = "R7";
    startPage(3, 0);
    sendRes(200, 1, 0); sendRes(64, 1, 0); sendRes(63, 1, 0);
    idle(1);
    startPage(2, 0);
    sendRes(40, 1, 0); sendRes(255, 1, 0);
    idle(2);

    curReq = "R8";
    startPage(0, 0);
    for (int i = 0; i < 16; i++) sendRes(i, 1, 0);
    idle(2);

    curReq = "R9";
    startPage(3, 0);
    sendRes(4, 0, 1); sendRes(1, 1, 1); sendRes(2, 0, 1);
    idle(1);
    startPage(3, 0);
    sendRes(0, 1, 1); sendRes(0, 1, 0); sendRes(0, 1, 1);
    idle(1);

    curReq = "R10";
    startPage(2, 0);
    sendRes(5, 1, 0); sendRes(6, 1, 1); sendRes(60, 0, 1); sendRes(61, 0, 0);
    idle(2);

    curReq = "R3";
    startPage(3, 1);
    sendRes(8, 1, 0);
    @(negedge clk);
    pageStart = 1; pktCount = 2; resValid = 1; resErrCnt = 30; resDecodeOk = 0;
    sendRes(11, 1, 0); sendRes(13, 0, 0);
    idle(2);

    curReq = "R2 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pageStart = ($urandom_range(0, 9) == 0);
      pktCount = PKT_W'($urandom_range(0, 5));
      resValid = ($urandom_range(0, 2) != 0);
      resErrCnt = ERR_IN_W'($urandom_range(0, 90));
      resDecodeOk = ($urandom_range(0, 4) != 0);
      resErased = ($urandom_range(0, 2) == 0);
    end
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nMismatched++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end
endmodule